// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from a radio transceiver core into two 8-bit status registers. Each status register has a matching 8-bit enable register. The block drives one active-low interrupt request pin, `irq_n_o`. That pin is low whenever any status bit is set together with its enable bit. A disabled event still latches its status bit, so a host can poll for it, but it never pulls the pin low.

A host reaches the four registers through a plain single-cycle register bus made of address, write enable, write data, read strobe and read data. The bus has no handshake and accepts an access on every clock, so there is never any back-pressure. Read data is registered and appears the cycle after the strobe. It carries the register value as it stood before the access.

A read of a status register clears the bits in it that are enabled, and the pin is then re-evaluated. Bits whose enable is clear are left untouched. Two sources get special handling. The power-on-reset event and the chip-ready event are enabled out of reset. The power-on-reset bit is also kept off the pin until the first status read that clears a pending enabled bit.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After reset both status registers read 00h, enable register one reads 00h, enable register two reads 03h, and `irq_n_o` is high.
- R2: Register addresses are 03h for status one, 04h for status two, 05h for enable one and 06h for enable two. Any other address reads 00h. `rd_data_o` shows the addressed value, taken before any clear, one clock after `rd_en_i`, and holds that value until the next read.
- R3: A high bit on `evt1_i` or `evt2_i` in a cycle sets the matching status bit at that clock edge, whatever the state of its enable bit.
- R4: A read of 03h or 04h clears exactly those bits of that status register whose enable bit is 1. Bits whose enable bit is 0 keep their value.
- R5: Enable register two holds, from bit 7 down to bit 0: sync-word detect, valid preamble, invalid preamble, signal strength, wake-up timer, low battery, chip ready (bit 1) and power-on reset (bit 0). Enable register one holds FIFO error, TX almost full, TX almost empty, RX almost full, external, packet sent, packet valid and CRC error, also from bit 7 down to bit 0.
- R6: If an event pulse arrives in the same cycle as a read that would clear its bit, the bit is set after that edge.
- R7: `irq_n_o` is low exactly when some status bit and its enable bit are both 1. The only exception is the case covered by R8. The pin follows the register state, so it changes in the cycle after the edge that updated a status or enable register.
- R8: From reset until the first status read that clears at least one set, enabled bit, status two bit 0 (power-on reset) is left out of the `irq_n_o` equation. After that read it counts like any other bit.
- R9: Writes to 03h and 04h change nothing. Writes to 05h and 06h replace the whole enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt1_i | input | 8 | Event pulses for status register one |
| evt2_i | input | 8 | Event pulses for status register two |
| addr_i | input | 8 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Registered read data |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The bench goes after four hazards.

The first is the power-on-reset mask. A design that never masks would pull the pin low on the first reset event. A design that never unmasks would keep the pin high after the first clearing read.

The second is the enabled-only clear. A design that clears the whole register would lose disabled events that software polls for.

The third is an event that coincides with a clearing read. If clear has priority over set, the bit vanishes and the interrupt is lost.

The fourth is the access paths. Writes to status addresses must be ignored, unmapped addresses must read zero, and read data must come from before the clear. Otherwise software would see zeros or stale enables.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_ST1 = 8'h03;
  localparam logic [ADDR_W-1:0] ADDR_ST2 = 8'h04;
  localparam logic [ADDR_W-1:0] ADDR_EN1 = 8'h05;
  localparam logic [ADDR_W-1:0] ADDR_EN2 = 8'h06;
  localparam logic [DATA_W-1:0] EN1_RST  = 8'h00;
  localparam logic [DATA_W-1:0] EN2_RST  = 8'h03;
  localparam int POR_BIT = 0;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // set wins over clear so a coincident event survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= RST;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/irq_pin_gen.sv
module irq_pin_gen #(
  parameter int W = 8,
  parameter int MASK_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] st1_i,
  input  logic [W-1:0] en1_i,
  input  logic [W-1:0] st2_i,
  input  logic [W-1:0] en2_i,
  input  logic         first_clr_i,
  output logic         por_mask_o,
  output logic         irq_n_o
);
  logic [W-1:0] gate2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           por_mask_o <= 1'b1;
    else if (first_clr_i) por_mask_o <= 1'b0;
  end

  always_comb begin
    gate2 = en2_i;
    if (por_mask_o) gate2[MASK_BIT] = 1'b0;
    irq_n_o = ~(|(st1_i & en1_i) | |(st2_i & gate2));
  end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt1_i,
  input  logic [DATA_W-1:0] evt2_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_n_o
);
  word_t st1_q, st2_q, en1_q, en2_q;
  word_t clr1, clr2;
  logic  rd_st1, rd_st2, first_clr, por_mask;

  assign rd_st1 = rd_en_i && (addr_i == ADDR_ST1);
  assign rd_st2 = rd_en_i && (addr_i == ADDR_ST2);
  assign clr1   = rd_st1 ? en1_q : '0;
  assign clr2   = rd_st2 ? en2_q : '0;
  // a read that actually removes a pending enabled bit lifts the reset mask
  assign first_clr = |(st1_q & clr1) | |(st2_q & clr2);

  irq_status_reg #(.W(DATA_W)) u_st1 (
    .clk(clk), .rst_n(rst_n), .set_i(evt1_i), .clr_i(clr1), .q_o(st1_q));
  irq_status_reg #(.W(DATA_W)) u_st2 (
    .clk(clk), .rst_n(rst_n), .set_i(evt2_i), .clr_i(clr2), .q_o(st2_q));

  irq_enable_reg #(.W(DATA_W), .RST(EN1_RST)) u_en1 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en_i && (addr_i == ADDR_EN1)),
    .d_i(wr_data_i), .q_o(en1_q));
  irq_enable_reg #(.W(DATA_W), .RST(EN2_RST)) u_en2 (
    .clk(clk), .rst_n(rst_n), .we_i(wr_en_i && (addr_i == ADDR_EN2)),
    .d_i(wr_data_i), .q_o(en2_q));

  irq_pin_gen #(.W(DATA_W), .MASK_BIT(POR_BIT)) u_pin (
    .clk(clk), .rst_n(rst_n), .st1_i(st1_q), .en1_i(en1_q),
    .st2_i(st2_q), .en2_i(en2_q), .first_clr_i(first_clr),
    .por_mask_o(por_mask), .irq_n_o(irq_n_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data_o <= '0;
    else if (rd_en_i) begin
      unique case (addr_i)
        ADDR_ST1: rd_data_o <= st1_q;
        ADDR_ST2: rd_data_o <= st2_q;
        ADDR_EN1: rd_data_o <= en1_q;
        ADDR_EN2: rd_data_o <= en2_q;
        default:  rd_data_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/radio_irq_ctrl_chk.sv
module radio_irq_ctrl_chk
  import irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] evt1_i,
  input logic [DATA_W-1:0] evt2_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              irq_n_o,
  input logic [DATA_W-1:0] st1,
  input logic [DATA_W-1:0] st2,
  input logic [DATA_W-1:0] en1,
  input logic [DATA_W-1:0] en2,
  input logic              por_mask
);
  assert_evt_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st1 & $past(evt1_i)) == $past(evt1_i)) &&
             ((st2 & $past(evt2_i)) == $past(evt2_i)));

  assert_enabled_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_ST1 && evt1_i == '0) |=> st1 == ($past(st1) & ~$past(en1)));

  assert_status_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !rd_en_i && addr_i == ADDR_ST2 && evt2_i == '0) |=> st2 == $past(st2));

  assert_rd_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i == ADDR_EN2) |=> rd_data_o == $past(en2));

  assert_mask_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !por_mask |=> !por_mask);

  assert_por_hidden_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (por_mask && (st1 & en1) == '0 && (st2 & en2 & 8'hFE) == '0) |-> irq_n_o);
endmodule

bind radio_irq_ctrl radio_irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .evt1_i(evt1_i), .evt2_i(evt2_i), .addr_i(addr_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_n_o(irq_n_o),
  .st1(st1_q), .st2(st2_q), .en1(en1_q), .en2(en2_q), .por_mask(por_mask));

// File: tb/sim_radio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_radio_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt1 = '0, evt2 = '0, addr = '0, wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m_st1 = 0, m_st2 = 0, m_en1 = 8'h00, m_en2 = 8'h03;
  bit m_mask = 1;
  logic [7:0] got;

  always #2 clk = ~clk;

  radio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .evt1_i(evt1), .evt2_i(evt2), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .irq_n_o(irq_n));

  function automatic logic exp_irq_n(logic [7:0] s1, logic [7:0] e1,
                                     logic [7:0] s2, logic [7:0] e2, bit mk);
    logic [7:0] g2;
    g2 = e2;
    if (mk) g2[0] = 1'b0;
    return !(|(s1 & e1) || |(s2 & g2));
  endfunction

  function automatic logic [7:0] exp_rd(logic [7:0] a);
    case (a)
      8'h03: return m_st1;
      8'h04: return m_st2;
      8'h05: return m_en1;
      8'h06: return m_en2;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one bus cycle, entered and left at a falling edge
  task automatic tick(logic [7:0] e1, logic [7:0] e2, bit rd, bit wr,
                      logic [7:0] a, logic [7:0] d);
    logic [7:0] rv, c1, c2;
    evt1 = e1; evt2 = e2; rd_en = rd; wr_en = wr; addr = a; wdata = d;
    rv = exp_rd(a);
    c1 = (rd && a == 8'h03) ? m_en1 : 8'h00;
    c2 = (rd && a == 8'h04) ? m_en2 : 8'h00;
    @(posedge clk);
    if (|(m_st1 & c1) || |(m_st2 & c2)) m_mask = 0;
    m_st1 = (m_st1 & ~c1) | e1;
    m_st2 = (m_st2 & ~c2) | e2;
    if (wr && a == 8'h05) m_en1 = d;
    if (wr && a == 8'h06) m_en2 = d;
    @(negedge clk);
    evt1 = 0; evt2 = 0; rd_en = 0; wr_en = 0;
    chk("R7 pin", {7'b0, irq_n}, {7'b0, exp_irq_n(m_st1, m_en1, m_st2, m_en2, m_mask)});
    if (rd) begin
      got = rd_data;
      chk("R2 read", rd_data, rv);
    end
  endtask

  task automatic rd(logic [7:0] a); tick(0, 0, 1, 0, a, 0); endtask
  task automatic wr(logic [7:0] a, logic [7:0] d); tick(0, 0, 0, 1, a, d); endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pin", {7'b0, irq_n}, 8'h01);
    rd(8'h03); chk("R1 st1", got, 8'h00);
    rd(8'h04); chk("R1 st2", got, 8'h00);
    rd(8'h05); chk("R1 en1", got, 8'h00);
    rd(8'h06); chk("R1 en2", got, 8'h03);
    // R8 power-on reset hidden until first clear; R5 bit 0 is por
    tick(0, 8'h01, 0, 0, 0, 0);
    chk("R8 por masked", {7'b0, irq_n}, 8'h01);
    rd(8'h04); chk("R3 por latched", got, 8'h01);
    chk("R8 pin after clear", {7'b0, irq_n}, 8'h01);
    tick(0, 8'h01, 0, 0, 0, 0);
    chk("R8 por unmasked", {7'b0, irq_n}, 8'h00);
    rd(8'h04);
    chk("R4 cleared pin", {7'b0, irq_n}, 8'h01);
    // R5 chip ready at bit 1 enabled by default
    tick(0, 8'h02, 0, 0, 0, 0);
    chk("R5 chip ready pin", {7'b0, irq_n}, 8'h00);
    rd(8'h04); chk("R5 chip ready read", got, 8'h02);
    // R3 R4 disabled event latches and survives a read
    tick(8'h80, 0, 0, 0, 0, 0);
    chk("R3 disabled no pin", {7'b0, irq_n}, 8'h01);
    rd(8'h03); chk("R3 disabled latched", got, 8'h80);
    rd(8'h03); chk("R4 disabled kept", got, 8'h80);
    wr(8'h05, 8'h80);
    chk("R7 enable raises pin", {7'b0, irq_n}, 8'h00);
    rd(8'h03); chk("R4 pre-clear value", got, 8'h80);
    rd(8'h03); chk("R4 cleared", got, 8'h00);
    // R9 status writes ignored, enable readback
    wr(8'h03, 8'hFF); wr(8'h04, 8'hFF);
    rd(8'h03); chk("R9 st1 write ignored", got, 8'h00);
    rd(8'h04); chk("R9 st2 write ignored", got, 8'h00);
    wr(8'h06, 8'hA5); rd(8'h06); chk("R9 en2 write", got, 8'hA5);
    // R6 coincident event and clearing read
    wr(8'h05, 8'hFF);
    tick(8'h01, 0, 0, 0, 0, 0);
    tick(8'h01, 0, 1, 0, 8'h03, 0); chk("R6 read value", got, 8'h01);
    rd(8'h03); chk("R6 bit survived", got, 8'h01);
    rd(8'h03); chk("R6 then cleared", got, 8'h00);
    // R2 unmapped address
    rd(8'h07); chk("R2 unmapped", got, 8'h00);
    rd(8'h00); chk("R2 unmapped low", got, 8'h00);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] e1, e2, a, d;
      bit r, w;
      e1 = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      e2 = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      a = 8'(2 + $urandom % 6);
      r = ($urandom % 3 == 0);
      w = ($urandom % 6 == 0);
      d = 8'($urandom);
      tick(e1, e2, r, w, a, d);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule